// File: doc/BRIEF.md
# Interrupt Pending and Enable Register Bank

This block is the interrupt-facing register group of a serial bus controller. Single-cycle event pulses from the transfer engine latch into a sticky pending register. Software reads that register and acknowledges events by writing ones back to it. Writes of zero leave bits untouched.

The per-source enables live in a mask vector. Software never writes the mask directly. One write-only port clears mask bits, which unmasks those sources. A second write-only port sets mask bits, which masks them. A read-only view of the mask sits at a separate offset.

A single level request line is high while any pending source is also unmasked. All four views share one bit layout, and bit 8 is not implemented. The register bus is a plain 32-bit write/read strobe interface. Read data is combinational and returns zero whenever no read is requested.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset, all pending bits are 0 and every implemented source is masked, so the mask view reads 0x2FF. The request line is low.
- R2: A pulse on event input i sets pending bit i at the next clock edge, even when source i is masked. The bit then holds until it is cleared. The positions are: 9 arbitration lost, 7 receive underflow, 6 transmit overflow, 5 receive overflow, 4 target ready, 3 timeout, 2 no acknowledge, 1 data threshold, 0 transfer complete.
- R3: A write to offset 0x10 clears the pending bits where the write data has ones. Bits where the write data has zeros are left unchanged.
- R4: If an event pulse and a clear of the same bit occur in the same cycle, the bit is set after the edge.
- R5: A write to offset 0x24 clears the mask bits where the write data has ones, which enables those sources. Zero bits have no effect.
- R6: A write to offset 0x28 sets the mask bits where the write data has ones, which disables those sources. Zero bits have no effect.
- R7: The request line is high exactly when some pending bit is set and its mask bit is clear.
- R8: Bit 8 and bits 31:10 always read as zero in both the pending view and the mask view. A pulse on event input 8 has no effect.
- R9: Reading offset 0x10 returns the pending bits, and reading offset 0x20 returns the mask. Reads of 0x24, 0x28, any other offset, or any cycle without a read return zero.
- R10: Writes to 0x20 or to any unassigned offset change neither the pending bits nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_pulse | input | 10 | One-cycle event pulses, one per source |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that write and read strobes never address two registers at once, and that event inputs are clean single-cycle levels sampled at the clock edge. The bench changes inputs only on the falling edge and issues at most one write per cycle. It keeps clear writes, enable and disable writes, and event pulses within those rules, including events that collide with clears of the same bit. A pulse on the unimplemented event input is also driven on purpose, to show that it is ignored rather than relied on.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    localparam int IRQB_NSRC   = 10;
    localparam int IRQB_ADDR_W = 8;
    localparam int IRQB_DATA_W = 32;

    // Bit 8 is not implemented.
    localparam logic [IRQB_NSRC-1:0] IRQB_IMPL = 10'b10_1111_1111;

    localparam logic [IRQB_ADDR_W-1:0] OFS_PEND   = 8'h10;
    localparam logic [IRQB_ADDR_W-1:0] OFS_MASKRB = 8'h20;
    localparam logic [IRQB_ADDR_W-1:0] OFS_ENA    = 8'h24;
    localparam logic [IRQB_ADDR_W-1:0] OFS_DIS    = 8'h28;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PEND = 2'd1,
        RSEL_MASK = 2'd2
    } rsel_e;

    typedef struct packed {
        logic clr;  // acknowledge pending bits
        logic ena;  // clear mask bits
        logic dis;  // set mask bits
    } wstrb_t;

    function automatic logic any_set(input logic [IRQB_NSRC-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
#(
    parameter int ADDR_W = IRQB_ADDR_W,
    parameter logic [ADDR_W-1:0] A_PEND   = OFS_PEND,
    parameter logic [ADDR_W-1:0] A_MASKRB = OFS_MASKRB,
    parameter logic [ADDR_W-1:0] A_ENA    = OFS_ENA,
    parameter logic [ADDR_W-1:0] A_DIS    = OFS_DIS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output wstrb_t            wstrb,
    output rsel_e             rsel
);

    always_comb begin
        wstrb = '0;
        if (wr) begin
            wstrb.clr = (addr == A_PEND);
            wstrb.ena = (addr == A_ENA);
            wstrb.dis = (addr == A_DIS);
        end
    end

    always_comb begin
        rsel = RSEL_NONE;
        if (rd) begin
            if (addr == A_PEND)
                rsel = RSEL_PEND;
            else if (addr == A_MASKRB)
                rsel = RSEL_MASK;
        end
    end

    // R10: at most one register is written in any cycle
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wstrb.clr, wstrb.ena, wstrb.dis}));

endmodule

// File: rtl/irqb_pending.sv
module irqb_pending
    import irqb_pkg::*;
#(
    parameter int NSRC = IRQB_NSRC,
    parameter logic [NSRC-1:0] IMPL = IRQB_IMPL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] pend
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (evt[i])
                    q <= 1'b1;          // event beats a same-cycle clear
                else if (clr_we && clr_bits[i])
                    q <= 1'b0;
            end
            assign pend[i] = q;

            p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> pend[i]);
            p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
                (!evt[i] && !(clr_we && clr_bits[i])) |=> $stable(pend[i]));
            p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
                (clr_we && clr_bits[i] && !evt[i]) |=> !pend[i]);
            p_evt_wins_r4: assert property (@(posedge clk) disable iff (rst)
                (clr_we && clr_bits[i] && evt[i]) |=> pend[i]);
        end else begin : g_tie
            assign pend[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irqb_mask.sv
module irqb_mask
    import irqb_pkg::*;
#(
    parameter int NSRC = IRQB_NSRC,
    parameter logic [NSRC-1:0] IMPL = IRQB_IMPL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ena_we,
    input  logic            dis_we,
    input  logic [NSRC-1:0] bits,
    output logic [NSRC-1:0] mask
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b1;
                else if (ena_we && bits[i])
                    q <= 1'b0;
                else if (dis_we && bits[i])
                    q <= 1'b1;
            end
            assign mask[i] = q;

            p_enable_r5: assert property (@(posedge clk) disable iff (rst)
                (ena_we && bits[i]) |=> !mask[i]);
            p_disable_r6: assert property (@(posedge clk) disable iff (rst)
                (dis_we && bits[i] && !ena_we) |=> mask[i]);
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !((ena_we || dis_we) && bits[i]) |=> $stable(mask[i]));
        end else begin : g_tie
            assign mask[i] = 1'b0;
        end
    end

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import irqb_pkg::*;
#(
    parameter int NSRC   = IRQB_NSRC,
    parameter int ADDR_W = IRQB_ADDR_W,
    parameter int DATA_W = IRQB_DATA_W,
    parameter logic [NSRC-1:0] IMPL = IRQB_IMPL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   evt_pulse,
    output logic              irq
);

    localparam logic [DATA_W-1:0] RD_KEEP = DATA_W'(IMPL);

    wstrb_t          wstrb;
    rsel_e           rsel;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] wbits;
    logic            unused_wdata_hi;

    assign wbits           = bus_wdata[NSRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NSRC];

    irqb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .wstrb (wstrb),
        .rsel  (rsel)
    );

    irqb_pending #(.NSRC(NSRC), .IMPL(IMPL)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .clr_we   (wstrb.clr),
        .clr_bits (wbits),
        .pend     (pend)
    );

    irqb_mask #(.NSRC(NSRC), .IMPL(IMPL)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .ena_we (wstrb.ena),
        .dis_we (wstrb.dis),
        .bits   (wbits),
        .mask   (mask)
    );

    always_comb begin
        unique case (rsel)
            RSEL_PEND: bus_rdata = DATA_W'(pend);
            RSEL_MASK: bus_rdata = DATA_W'(mask);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = any_set(pend & ~mask);

    // R7: with every source masked the request stays low
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mask == IMPL) |-> !irq);
    // R7: a request needs at least one pending bit
    p_needs_pend_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend != '0));

    // R8: unimplemented bits never show on the read bus
    always_comb begin
        if (!rst)
            p_unused_zero_r8: assert ((bus_rdata & ~RD_KEEP) == '0);
    end

endmodule

// File: tb/evt_irq_regs_test.sv
module evt_irq_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  evt_pulse = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state
    int m_pend = 0;
    int m_mask = 'h2FF;
    localparam int IMPL = 'h2FF;

    always #4 clk = ~clk;

    evt_irq_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    function automatic int ref_read(bit rd, int a);
        if (!rd) return 0;
        if (a == 'h10) return m_pend;
        if (a == 'h20) return m_mask;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at falling edge, check, then update the model at the rising edge
    task automatic cyc(bit wr, bit rd, int a, int wd, int ev, string tag);
        bus_wr = wr; bus_rd = rd; bus_addr = 8'(a);
        bus_wdata = 32'(wd); evt_pulse = 10'(ev);
        #1;
        check({tag, " rdata"}, int'(bus_rdata), ref_read(rd, a));
        check({tag, " irq"}, int'(irq), int'((m_pend & ~m_mask) != 0));
        @(posedge clk);
        if (wr && a == 'h10) m_pend = m_pend & ~(wd & 'h3FF);
        m_pend = (m_pend | ev) & IMPL;
        if (wr && a == 'h24) m_mask = m_mask & ~wd;
        if (wr && a == 'h28) m_mask = m_mask | wd;
        m_mask = m_mask & IMPL;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lfsr = 32'h1ACE5;
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cyc(0, 1, 'h20, 0, 0, "R1 mask after reset");
        cyc(0, 1, 'h10, 0, 0, "R1 pending after reset");
        // R2 events captured while masked
        cyc(0, 0, 0, 0, 'h205, "R2 events while masked");
        cyc(0, 1, 'h10, 0, 0, "R2 pending holds 0x205");
        // R8 bit 8 event ignored
        cyc(0, 0, 0, 0, 'h100, "R8 event on bit 8");
        cyc(0, 1, 'h10, 0, 0, "R8 bit 8 reads zero");
        // R5 enable bit 2, R9 read of enable offset
        cyc(1, 0, 'h24, 'h4, 0, "R5 enable bit 2");
        cyc(0, 1, 'h24, 0, 0, "R9 enable offset reads zero");
        cyc(0, 1, 'h20, 0, 0, "R5 mask readback");
        // R3 clear bit 2 only
        cyc(1, 0, 'h10, 'h4, 0, "R3 clear bit 2");
        cyc(0, 1, 'h10, 0, 0, "R3 other bits remain");
        // R4 event and clear in one cycle
        cyc(1, 0, 'h10, 'h201, 'h1, "R4 collide on bit 0");
        cyc(0, 1, 'h10, 0, 0, "R4 bit 0 still set");
        // R7 enable bit 0 raises irq, R6 disable drops it
        cyc(1, 0, 'h24, 'h1, 0, "R7 enable bit 0");
        cyc(0, 0, 0, 0, 0, "R7 irq high");
        cyc(1, 0, 'h28, 'hFFFFFFFF, 0, "R6 disable all");
        cyc(0, 1, 'h28, 0, 0, "R9 disable offset reads zero");
        cyc(0, 1, 'h20, 0, 0, "R6 mask all set");
        // R10 writes to readback and free offsets ignored
        cyc(1, 0, 'h20, 'h3FF, 'h0, "R10 write mask view");
        cyc(1, 0, 'h04, 'h3FF, 'h0, "R10 write free offset");
        cyc(0, 1, 'h20, 0, 0, "R10 mask unchanged");
        cyc(0, 1, 'h10, 0, 0, "R10 pending unchanged");
        cyc(0, 1, 'h04, 0, 0, "R9 free offset reads zero");
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            int op, a, wd, ev;
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) ? 32'h04C11DB7 : 0);
            op = (lfsr >>> 3) & 7;
            wd = lfsr ^ (lfsr >>> 11);
            ev = ((lfsr >>> 5) & (lfsr >>> 17)) & 'h3FF;
            case (op)
                0: cyc(1, 0, 'h10, wd, ev, "R3 mixed clear");
                1: cyc(1, 0, 'h24, wd & 'h3F, ev, "R5 mixed enable");
                2: cyc(1, 0, 'h28, wd & 'h3C0, ev, "R6 mixed disable");
                3: cyc(0, 1, 'h10, 0, ev, "R2 mixed read pending");
                4: cyc(0, 1, 'h20, 0, ev, "R7 mixed read mask");
                default: begin
                    a = (wd & 'hF) << 2;
                    cyc(0, 1, a, 0, ev, "R9 mixed read any");
                end
            endcase
        end
        // R1 reset again mid-run
        rst = 1'b1;
        @(posedge clk);
        m_pend = 0; m_mask = IMPL;
        @(negedge clk);
        rst = 1'b0;
        cyc(0, 1, 'h20, 0, 0, "R1 mask after second reset");
        cyc(0, 1, 'h10, 0, 0, "R1 pending after second reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule